// File: doc/BRIEF.md
# Multi-Port Memory Address Decoder

This block is the address steering logic that sits in front of a shared main memory with eight request ports. Each port presents a word address, a valid strobe and its own address-mode setting. A set of shared configuration inputs describes the memory unit: the start of its address window, how many 64K-word banks it holds, which banks are switched on, the interleave scheme, and (for four-way interleave) which half of a unit pair this unit is. For every port the block decides whether this unit answers the request. When it does, the block also reports which of the two internal controllers takes the cycle, which bank is addressed, and the word offset inside that bank.

The decode is combinational from the port inputs, and its results are registered, so a request is answered on the clock edge after it is presented. Next to the decoder, each port has a parity path. Odd parity is generated over the 36 write-data bits. Parity is checked on read data, and a per-port error flag is raised in the same cycle that the read data is presented.

Top module: `mem_port_decoder`

## Requirements
- R1: All eight ports are decoded independently by identical logic. The result on one port does not depend on the inputs of any other port.
- R2: A port's mode code selects how its address is used. Code 0 disables the port, and so does code 3. Code 1 is 18-bit mode, in which address bits 21..18 are forced to zero before decode. Code 2 is 22-bit mode, which uses the full address. A disabled port never hits.
- R3: A port hits only when its effective address E satisfies base <= E < base + span. The span is the bank count times 65536, doubled in four-way interleave mode. The local address L is E − base.
- R4: The bank-count code maps 0, 1 and 2 to 1, 2 and 4 banks. Code 3 is illegal and produces no hits. A request that lands in a bank whose enable bit (bankEn[bank]) is low does not hit.
- R5: Interleave code 0 means no interleave, and code 3 is treated the same way. In this mode the controller is L[15], the bank is L[17:16] and the offset is L[15:0].
- R6: Interleave code 1 is two-way interleave. Bits 0 and 15 of L are exchanged before the bank, offset and controller are taken as in R5. Even local addresses therefore go to controller 0 and odd ones to controller 1.
- R7: Interleave code 2 is four-way interleave. L[1] names the unit of the pair, and the port hits only if L[1] equals unitId. The remaining address {L[21:2], L[0]} is then decoded as in R6.
- R8: wrParity[p] is the odd-parity bit of wrData[p]: the 37 bits together contain an odd number of ones. It is combinational.
- R9: rdParErr[p] is high in the same cycle when rdValid[p] is high and {rdData[p], rdParity[p]} holds an even number of ones. It is low otherwise.
- R10: The decode outputs are registered with one cycle of latency. A cycle without a hit gives zero controller, bank and offset. Reset clears all decode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 22 | First word address of this unit's window |
| bankCount | input | 2 | Bank-count code |
| bankEn | input | 4 | Per-bank enable |
| ilvMode | input | 2 | Interleave code |
| unitId | input | 1 | Unit identity within a four-way pair |
| reqValid | input | 8 | Per-port request strobe |
| reqMode | input | 8x2 | Per-port address mode code |
| reqAddr | input | 8x22 | Per-port word address |
| selHit | output | 8 | Per-port select, one cycle after request |
| selCtl | output | 8 | Servicing controller index |
| selBank | output | 8x2 | Bank index |
| selOffset | output | 8x16 | Word offset within bank |
| wrData | input | 8x36 | Per-port write data |
| wrParity | output | 8 | Generated parity bit |
| rdValid | input | 8 | Per-port read-data strobe |
| rdData | input | 8x36 | Per-port read data |
| rdParity | input | 8 | Stored parity bit returned with read data |
| rdParErr | output | 8 | Read parity mismatch flag |

## Verification
The assertions treat the configuration inputs as ordinary inputs sampled on the same edge as the request, so they stay valid when the configuration changes. The stimulus changes configuration only between phases, with one idle cycle in between. The controller-equals-address-LSB property holds only when the base address is even, and its antecedent is restricted to that case. The stimulus mostly uses bases on 64K boundaries, and it includes one phase with an odd base so that the R3 arithmetic is exercised without that property. Addresses are aimed at the window edges (base − 1, base, last word, one past the end) as well as at random points around the window. In 18-bit mode, random upper bits are driven so that their masking is exercised.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  parameter int ADDR_W     = 22;
  parameter int NARROW_W   = 18;
  parameter int OFFS_W     = 16;
  parameter int BANK_SEL_W = 2;
  parameter int MAX_BANKS  = 1 << BANK_SEL_W;
  parameter int CTL_BIT    = OFFS_W - 1;
  parameter int SPAN_W     = ADDR_W + 2;

  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_NARROW = 2'd1,
    PM_WIDE   = 2'd2,
    PM_OFF_X  = 2'd3
  } portMode_e;

  typedef enum logic [1:0] {
    IL_NONE = 2'd0,
    IL_TWO  = 2'd1,
    IL_FOUR = 2'd2,
    IL_RSVD = 2'd3
  } ilvMode_e;

  // Strobes from the configuration control to the per-port datapath
  typedef struct packed {
    logic              cfgOk;
    logic              swapCtl;
    logic              unitSplit;
    logic [SPAN_W-1:0] spanWords;
  } decStrobe_t;
endpackage

// File: rtl/mpd_ctrl.sv
module mpd_ctrl
  import mpd_pkg::*;
(
  input  logic [1:0]  bankCount,
  input  logic [1:0]  ilvMode,
  output decStrobe_t  strobes
);
  logic [BANK_SEL_W:0] bankLimit;
  logic [SPAN_W-1:0]   unitSpan;

  always_comb begin
    strobes.cfgOk = 1'b1;
    case (bankCount)
      2'd0:    bankLimit = (BANK_SEL_W+1)'(1);
      2'd1:    bankLimit = (BANK_SEL_W+1)'(2);
      2'd2:    bankLimit = (BANK_SEL_W+1)'(MAX_BANKS);
      default: begin
        bankLimit     = '0;
        strobes.cfgOk = 1'b0;
      end
    endcase
    unitSpan          = SPAN_W'(bankLimit) << OFFS_W;
    strobes.unitSplit = (ilvMode == IL_FOUR);
    strobes.swapCtl   = (ilvMode == IL_TWO) || (ilvMode == IL_FOUR);
    strobes.spanWords = strobes.unitSplit ? (unitSpan << 1) : unitSpan;
  end
endmodule

// File: rtl/mpd_parity.sv
module mpd_parity #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 36
) (
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wrData,
  output logic [NUM_PORTS-1:0]             wrParity,
  input  logic [NUM_PORTS-1:0]             rdValid,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] rdData,
  input  logic [NUM_PORTS-1:0]             rdParity,
  output logic [NUM_PORTS-1:0]             rdParErr
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_par
    always_comb begin
      wrParity[p] = ~(^wrData[p]);
      rdParErr[p] = rdValid[p] & ~(^{rdData[p], rdParity[p]});
    end
  end
endmodule

// File: rtl/mpd_datapath.sv
module mpd_datapath
  import mpd_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  decStrobe_t                            strobes,
  input  logic [ADDR_W-1:0]                     baseAddr,
  input  logic [MAX_BANKS-1:0]                  bankEn,
  input  logic                                  unitId,
  input  logic [NUM_PORTS-1:0]                  reqValid,
  input  logic [NUM_PORTS-1:0][1:0]             reqMode,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]      reqAddr,
  output logic [NUM_PORTS-1:0]                  selHit,
  output logic [NUM_PORTS-1:0]                  selCtl,
  output logic [NUM_PORTS-1:0][BANK_SEL_W-1:0]  selBank,
  output logic [NUM_PORTS-1:0][OFFS_W-1:0]      selOffset
);
  localparam int HI_W = ADDR_W - OFFS_W - BANK_SEL_W;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [ADDR_W-1:0]     effAddr, localAddr, packedAddr, swapped;
    logic [BANK_SEL_W-1:0] bankIdx;
    logic                  modeOk, aboveBase, inSpan, unitOk, bankOk, hitNext;

    always_comb begin
      modeOk    = (reqMode[p] == PM_NARROW) || (reqMode[p] == PM_WIDE);
      effAddr   = (reqMode[p] == PM_NARROW)
                ? {{(ADDR_W-NARROW_W){1'b0}}, reqAddr[p][NARROW_W-1:0]}
                : reqAddr[p];
      aboveBase = (effAddr >= baseAddr);
      localAddr = effAddr - baseAddr;
      inSpan    = ({2'b00, localAddr} < strobes.spanWords);
      unitOk    = !strobes.unitSplit || (localAddr[1] == unitId);
      packedAddr = strobes.unitSplit
                 ? {1'b0, localAddr[ADDR_W-1:2], localAddr[0]}
                 : localAddr;
      swapped = packedAddr;
      if (strobes.swapCtl) begin
        swapped[CTL_BIT] = packedAddr[0];
        swapped[0]       = packedAddr[CTL_BIT];
      end
      bankIdx = swapped[OFFS_W +: BANK_SEL_W];
      bankOk  = bankEn[bankIdx] && (swapped[ADDR_W-1 -: HI_W] == '0);
      hitNext = reqValid[p] && modeOk && strobes.cfgOk && aboveBase
             && inSpan && unitOk && bankOk;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        selHit[p]    <= 1'b0;
        selCtl[p]    <= 1'b0;
        selBank[p]   <= '0;
        selOffset[p] <= '0;
      end else begin
        selHit[p]    <= hitNext;
        selCtl[p]    <= hitNext & swapped[CTL_BIT];
        selBank[p]   <= hitNext ? bankIdx : '0;
        selOffset[p] <= hitNext ? swapped[OFFS_W-1:0] : '0;
      end
    end
  end
endmodule

// File: rtl/mem_port_decoder.sv
module mem_port_decoder
  import mpd_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 36
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [ADDR_W-1:0]                     baseAddr,
  input  logic [1:0]                            bankCount,
  input  logic [MAX_BANKS-1:0]                  bankEn,
  input  logic [1:0]                            ilvMode,
  input  logic                                  unitId,
  input  logic [NUM_PORTS-1:0]                  reqValid,
  input  logic [NUM_PORTS-1:0][1:0]             reqMode,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]      reqAddr,
  output logic [NUM_PORTS-1:0]                  selHit,
  output logic [NUM_PORTS-1:0]                  selCtl,
  output logic [NUM_PORTS-1:0][BANK_SEL_W-1:0]  selBank,
  output logic [NUM_PORTS-1:0][OFFS_W-1:0]      selOffset,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]      wrData,
  output logic [NUM_PORTS-1:0]                  wrParity,
  input  logic [NUM_PORTS-1:0]                  rdValid,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]      rdData,
  input  logic [NUM_PORTS-1:0]                  rdParity,
  output logic [NUM_PORTS-1:0]                  rdParErr
);
  decStrobe_t strobes;

  mpd_ctrl u_ctrl (
    .bankCount (bankCount),
    .ilvMode   (ilvMode),
    .strobes   (strobes)
  );

  mpd_datapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .baseAddr  (baseAddr),
    .bankEn    (bankEn),
    .unitId    (unitId),
    .reqValid  (reqValid),
    .reqMode   (reqMode),
    .reqAddr   (reqAddr),
    .selHit    (selHit),
    .selCtl    (selCtl),
    .selBank   (selBank),
    .selOffset (selOffset)
  );

  mpd_parity #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_par (
    .wrData   (wrData),
    .wrParity (wrParity),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdParity (rdParity),
    .rdParErr (rdParErr)
  );
endmodule

// File: rtl/mem_port_decoder_chk.sv
module mem_port_decoder_chk
  import mpd_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 36
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic [ADDR_W-1:0]                     baseAddr,
  input logic [1:0]                            bankCount,
  input logic [MAX_BANKS-1:0]                  bankEn,
  input logic [1:0]                            ilvMode,
  input logic                                  unitId,
  input logic [NUM_PORTS-1:0]                  reqValid,
  input logic [NUM_PORTS-1:0][1:0]             reqMode,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]      reqAddr,
  input logic [NUM_PORTS-1:0]                  selHit,
  input logic [NUM_PORTS-1:0]                  selCtl,
  input logic [NUM_PORTS-1:0][BANK_SEL_W-1:0]  selBank,
  input logic [NUM_PORTS-1:0][OFFS_W-1:0]      selOffset,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]      wrData,
  input logic [NUM_PORTS-1:0]                  wrParity,
  input logic [NUM_PORTS-1:0]                  rdValid,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]      rdData,
  input logic [NUM_PORTS-1:0]                  rdParity,
  input logic [NUM_PORTS-1:0]                  rdParErr
);
  logic [MAX_BANKS-1:0] prevBankEn;
  logic                 prevIllegal;

  always_ff @(posedge clk) begin
    prevBankEn  <= bankEn;
    prevIllegal <= (bankCount == 2'd3);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R2: disabled mode codes never hit
    a_r2_off_no_hit: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && (reqMode[p] == PM_OFF || reqMode[p] == PM_OFF_X)) |=> !selHit[p]);

    // R3: a full-width address below the base never hits
    a_r3_below_base: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && reqMode[p] == PM_WIDE && reqAddr[p] < baseAddr) |=> !selHit[p]);

    // R4: a hit always lands in a bank that was enabled
    a_r4_bank_enabled: assert property (@(posedge clk) disable iff (!rstN)
      selHit[p] |-> prevBankEn[selBank[p]]);

    // R4: illegal bank count gives no hit
    a_r4_illegal_count: assert property (@(posedge clk) disable iff (!rstN)
      prevIllegal |-> !selHit[p]);

    // R6: with even base and interleave on, controller follows the address LSB
    a_r6_ctl_is_lsb: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && (ilvMode == IL_TWO || ilvMode == IL_FOUR) && !baseAddr[0])
      |=> (!selHit[p] || selCtl[p] == $past(reqAddr[p][0])));

    // R8: write data plus generated bit has odd weight
    a_r8_wr_odd: assert property (@(posedge clk) disable iff (!rstN)
      ($countones({wrData[p], wrParity[p]}) % 2) == 1);

    // R9: flag is raised on an even-weight read and held low without read
    a_r9_rd_even_flags: assert property (@(posedge clk) disable iff (!rstN)
      (rdValid[p] && ($countones({rdData[p], rdParity[p]}) % 2) == 0) |-> rdParErr[p]);
    a_r9_no_read_no_flag: assert property (@(posedge clk) disable iff (!rstN)
      !rdValid[p] |-> !rdParErr[p]);

    // R10: no request, no select one cycle later, with outputs zeroed
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[p] |=> (!selHit[p] && !selCtl[p] && selBank[p] == '0 && selOffset[p] == '0));
  end
endmodule

bind mem_port_decoder mem_port_decoder_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mem_port_decoder.sv
`timescale 1ns/1ps
module tb_mem_port_decoder;
  localparam int NP = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [21:0] baseAddr = '0;
  logic [1:0]  bankCount = '0;
  logic [3:0]  bankEn = '0;
  logic [1:0]  ilvMode = '0;
  logic        unitId = 1'b0;
  logic [NP-1:0]         reqValid = '0;
  logic [NP-1:0][1:0]    reqMode = '0;
  logic [NP-1:0][21:0]   reqAddr = '0;
  logic [NP-1:0]         selHit, selCtl, wrParity, rdParErr;
  logic [NP-1:0][1:0]    selBank;
  logic [NP-1:0][15:0]   selOffset;
  logic [NP-1:0][DW-1:0] wrData = '0;
  logic [NP-1:0]         rdValid = '0;
  logic [NP-1:0][DW-1:0] rdData = '0;
  logic [NP-1:0]         rdParity = '0;

  always #2 clk = ~clk;

  mem_port_decoder dut (.*);

  int checks = 0;
  int fails = 0;
  logic [19:0] expDec [NP];
  logic [36:0] store [64];
  bit          stored [64];

  task automatic check(input string req, input int port, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s port %0d actual %h expected %h", req, port, act, exp);
    end
  endtask

  // Behavioural reference: returns {hit, ctl, bank[1:0], offset[15:0]}
  function automatic logic [19:0] refDecode(input logic v, input logic [1:0] m, input logic [21:0] a);
    longint ea, loc, span, lo, hi, bank;
    if (!v || m == 2'd0 || m == 2'd3 || bankCount == 2'd3) return '0;
    ea = (m == 2'd1) ? longint'(a) % 262144 : longint'(a);
    span = (longint'(1) << bankCount) * 65536 * ((ilvMode == 2'd2) ? 2 : 1);
    if (ea < longint'(baseAddr) || ea - longint'(baseAddr) >= span) return '0;
    loc = ea - longint'(baseAddr);
    if (ilvMode == 2'd2) begin
      if (((loc / 2) % 2) != longint'(unitId)) return '0;
      loc = (loc / 4) * 2 + (loc % 2);
    end
    if (ilvMode == 2'd1 || ilvMode == 2'd2) begin
      lo = loc % 2;
      hi = (loc / 32768) % 2;
      loc = loc - lo - hi * 32768 + lo * 32768 + hi;
    end
    bank = (loc / 65536) % 4;
    if (!bankEn[bank]) return '0;
    return {1'b1, 1'(loc / 32768), 2'(bank), 16'(loc % 65536)};
  endfunction

  function automatic logic [21:0] pickAddr();
    longint span, b, r;
    span = (longint'(1) << (bankCount == 2'd3 ? 1 : bankCount)) * 65536 * ((ilvMode == 2'd2) ? 2 : 1);
    b = longint'(baseAddr);
    case ($urandom % 8)
      0: r = b - 1;
      1: r = b;
      2: r = b + span - 1;
      3: r = b + span;
      default: r = b - 1000 + longint'($urandom % 32'(span + 2000));
    endcase
    if (r < 0) r = 0;
    return 22'(r);
  endfunction

  // One cycle: compare registered decode, drive new requests, exercise parity
  task automatic cycle(input bit active, input string tag);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(tag, p, longint'({selHit[p], selCtl[p], selBank[p], selOffset[p]}), longint'(expDec[p]));
    for (int p = 0; p < NP; p++) begin
      int k = $urandom % 10;
      reqValid[p] = active && ($urandom % 8 != 0);
      reqMode[p]  = (k < 6) ? 2'd2 : (k < 8) ? 2'd1 : 2'(k - 8 == 0 ? 0 : 3);
      reqAddr[p]  = pickAddr();
      if (reqMode[p] == 2'd1) reqAddr[p][21:18] = 4'($urandom);
      wrData[p] = {4'($urandom), 32'($urandom)};
    end
    for (int p = 0; p < NP; p++) expDec[p] = refDecode(reqValid[p], reqMode[p], reqAddr[p]);
    #0.5;
    for (int p = 0; p < NP; p++) begin
      int wk = $urandom % 64;
      check("R8", p, longint'(wrParity[p]), longint'(($countones(wrData[p]) % 2) == 0));
      store[wk] = {wrParity[p], wrData[p]};
      stored[wk] = 1'b1;
    end
    for (int p = 0; p < NP; p++) begin
      int rk = $urandom % 64;
      logic [36:0] w = stored[rk] ? store[rk] : 37'h1_0000_0000_0;
      bit bad = ($urandom % 4 == 0);
      if (bad) w[$urandom % 37] ^= 1'b1;
      rdValid[p]  = ($urandom % 4 != 0);
      rdData[p]   = w[35:0];
      rdParity[p] = w[36];
      if (!stored[rk]) bad = 1'b0;
    end
    #0.5;
    for (int p = 0; p < NP; p++)
      check("R9", p, longint'(rdParErr[p]),
            longint'(rdValid[p] && ($countones({rdData[p], rdParity[p]}) % 2) == 0));
  endtask

  task automatic phase(input logic [1:0] bc, input logic [1:0] il, input logic [21:0] b,
                       input logic [3:0] en, input logic u, input string tag, input int n);
    cycle(1'b0, tag);
    bankCount = bc; ilvMode = il; baseAddr = b; bankEn = en; unitId = u;
    for (int i = 0; i < n; i++) cycle(1'b1, tag);
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finishTest();
  end

  initial begin
    for (int i = 0; i < 64; i++) stored[i] = 1'b0;
    for (int p = 0; p < NP; p++) expDec[p] = '0;
    repeat (3) @(negedge clk);
    // R10: reset clears the decode outputs
    for (int p = 0; p < NP; p++)
      check("R10", p, longint'({selHit[p], selCtl[p], selBank[p], selOffset[p]}), 0);
    rstN = 1'b1;
    // R1 R2 R3 R5: single bank, no interleave, narrow and wide ports mixed
    phase(2'd0, 2'd0, 22'h000000, 4'b1111, 1'b0, "R5", 300);
    // R6: two-way interleave, two banks
    phase(2'd1, 2'd1, 22'h040000, 4'b1111, 1'b0, "R6", 300);
    // R7: four-way interleave, unit 1, one bank disabled (R4)
    phase(2'd2, 2'd2, 22'h100000, 4'b1011, 1'b1, "R7", 300);
    // R4: four banks with holes, no interleave, narrow-reachable base (R2)
    phase(2'd2, 2'd0, 22'h020000, 4'b0110, 1'b0, "R4", 300);
    // R4: illegal bank-count code never hits
    phase(2'd3, 2'd0, 22'h000000, 4'b1111, 1'b0, "R4", 200);
    // R3 R7: odd base, four-way, unit 0
    phase(2'd1, 2'd2, 22'h000001, 4'b1111, 1'b0, "R3", 300);
    // R5: reserved interleave code behaves as none
    phase(2'd1, 2'd3, 22'h080000, 4'b1101, 1'b0, "R5", 200);
    // R10: idle cycles give quiet outputs
    cycle(1'b0, "R10");
    cycle(1'b0, "R10");
    cycle(1'b0, "R10");
    finishTest();
  end
endmodule